// File: doc/BRIEF.md
# Mixed-width register access adapter

This block sits between a CPU-side bus and a 512-byte peripheral register space. The registers in that space are not all the same width. The bus may issue byte, halfword or word accesses to any of them, and each peripheral register only understands accesses at its own native width. The adapter converts each incoming request into one or more downstream transactions at the register's native width. All data is big-endian.

A width map, given as a parameter, assigns a native width to each aligned 4-byte group of the space. The map can mark a group as byte, halfword, word or unused. The adapter handles three cases:
- When the request is as wide as the target, it becomes a single transaction.
- When the request is narrower than the target, the adapter reads the aligned container. For a read, it returns the addressed lane. For a write, it merges the new data into that lane and writes the container back.
- When the request is wider than the target, it becomes a run of native-width transactions at ascending addresses, with the most significant part first.

When the request finishes, the adapter raises a one-cycle done strobe, together with the read data or an error flag.

Data on every data port is right-justified: a byte uses bits 7:0 and a halfword uses bits 15:0. The downstream side answers within the same cycle. A transaction is presented for exactly one cycle, and read data is taken from `dn_rdata` in that cycle.

Top module: `regw_adapter`

## Requirements
- R1: While reset is active and right after it, `busy`, `done` and `dn_valid` are low.
- R2: A request is answered with `done` and `err` high one cycle after it is accepted, with no downstream transaction and `rdata` zero, in any of these cases:
  - `req_addr` bit 9 is set;
  - `req_size` is 0;
  - the address is misaligned for the size (halfword at an odd address, or word not a multiple of 4);
  - the target group is unused.
- R3: Size codes are 1 for byte, 2 for halfword and 3 for word. A request whose size equals the native width issues exactly one downstream transaction of that size at the request address.
- R4: A narrow read issues one read of the native-aligned container and returns the addressed big-endian lane. For example, a byte read returns the upper byte at an even address of a halfword register and the lower byte at an odd address.
- R5: A narrow write issues a container read followed by a container write. Only the addressed lane changes; the other bytes of the register keep their values.
- R6: A wide request issues S/N transactions (S = request bytes, N = native bytes) at ascending addresses, carrying the most significant part first. Read data is the concatenation of the parts in that order.
- R7: Every downstream transaction carries the size code of its target group and an address aligned to that size.
- R8: The default width map decodes address bits 7:6 of each group as follows: 00 byte, 01 halfword, 10 word, 11 unused. The pattern repeats every 256 bytes.
- R9: `done` is a single-cycle pulse. It comes in the cycle after the last downstream transaction, and `busy` stays high from acceptance through that cycle.
- R10: Read data and write effects match a plain big-endian byte memory, whatever mix of access widths is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (1 byte, 2 halfword, 3 word) |
| req_addr | input | 10 | Byte address of the access |
| req_wdata | input | 32 | Right-justified write data |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Error response, valid with `done` |
| rdata | output | 32 | Right-justified read data, valid with `done` |
| dn_valid | output | 1 | Downstream transaction this cycle |
| dn_write | output | 1 | Downstream write |
| dn_size | output | 2 | Downstream size code (native width) |
| dn_addr | output | 9 | Downstream byte address |
| dn_wdata | output | 32 | Downstream right-justified write data |
| dn_rdata | input | 32 | Downstream right-justified read data, same cycle |

## Verification
The assertions assume the following about the environment:
- `req_valid` is only raised while `busy` is low, so no request arrives during a sequence.
- The downstream side returns read data in the same cycle as the transaction.

The bench stays inside these assumptions: it drives one request at a time, waits for `busy` to fall before issuing the next, and models the register space as a zero-wait byte array that answers combinationally.

// File: rtl/regw_pkg.sv
package regw_pkg;
  localparam int ADDR_W  = 10;
  localparam int SPACE_AW = 9;
  localparam int GRP_AW  = SPACE_AW - 2;
  localparam int GRP_N   = 1 << GRP_AW;
  localparam int DATA_W  = 32;

  localparam logic [1:0] SZ_NONE = 2'd0;
  localparam logic [1:0] SZ_BYTE = 2'd1;
  localparam logic [1:0] SZ_HALF = 2'd2;
  localparam logic [1:0] SZ_WORD = 2'd3;

  function automatic logic [2:0] sz_bytes(input logic [1:0] code);
    return (code == SZ_WORD) ? 3'd4 : {1'b0, code};
  endfunction

  function automatic logic [DATA_W-1:0] byte_mask(input logic [2:0] n);
    case (n)
      3'd1:    return 32'h0000_00ff;
      3'd2:    return 32'h0000_ffff;
      3'd4:    return 32'hffff_ffff;
      default: return 32'h0;
    endcase
  endfunction

  // Bit shift of a narrow lane inside a big-endian container.
  function automatic logic [5:0] lane_shift(input logic [2:0] nat, input logic [2:0] acc,
                                            input logic [1:0] offs);
    int s;
    s = (int'(nat) - int'(acc) - int'(offs)) * 8;
    return 6'(s);
  endfunction

  // Bit shift of the piece still to be sent when 'left' pieces remain.
  function automatic logic [5:0] piece_shift(input logic [2:0] left, input logic [2:0] nat);
    int s;
    s = (int'(left) - 1) * int'(nat) * 8;
    return 6'(s);
  endfunction

  function automatic logic [2:0] op_count(input logic [2:0] acc, input logic [2:0] nat);
    return (nat == 3'd0) ? 3'd0 : 3'(acc / nat);
  endfunction

  function automatic logic [2*GRP_N-1:0] default_map();
    logic [2*GRP_N-1:0] m;
    m = '0;
    for (int g = 0; g < GRP_N; g++) begin
      logic [GRP_AW-1:0] gi;
      gi = GRP_AW'(g);
      m[2*g +: 2] = gi[5:4] + 2'd1;
    end
    return m;
  endfunction
endpackage

// File: rtl/regw_width_rom.sv
module regw_width_rom
  import regw_pkg::*;
#(
  parameter logic [2*GRP_N-1:0] MAP = default_map()
) (
  input  logic [GRP_AW-1:0] grp,
  output logic [1:0]        code
);
  logic [1:0] entry [GRP_N];

  for (genvar g = 0; g < GRP_N; g++) begin : g_entry
    assign entry[g] = MAP[2*g +: 2];
  end

  assign code = entry[grp];
endmodule

// File: rtl/regw_lane_unit.sv
module regw_lane_unit
  import regw_pkg::*;
(
  input  logic [DATA_W-1:0] container,
  input  logic [DATA_W-1:0] wdata,
  input  logic [2:0]        nat_bytes,
  input  logic [2:0]        acc_bytes,
  input  logic [1:0]        offs,
  output logic [DATA_W-1:0] extract,
  output logic [DATA_W-1:0] merged
);
  logic [5:0]        sh;
  logic [DATA_W-1:0] m;

  always_comb begin
    sh      = lane_shift(nat_bytes, acc_bytes, offs);
    m       = byte_mask(acc_bytes);
    extract = (container >> sh) & m;
    merged  = (container & ~(m << sh)) | ((wdata & m) << sh);
  end
endmodule

// File: rtl/regw_adapter.sv
module regw_adapter
  import regw_pkg::*;
#(
  parameter logic [2*GRP_N-1:0] WIDTH_MAP = default_map()
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [DATA_W-1:0]   rdata,
  output logic                dn_valid,
  output logic                dn_write,
  output logic [1:0]          dn_size,
  output logic [SPACE_AW-1:0] dn_addr,
  output logic [DATA_W-1:0]   dn_wdata,
  input  logic [DATA_W-1:0]   dn_rdata
);
  typedef enum logic [2:0] {ST_IDLE, ST_SPLIT, ST_RMW_RD, ST_RMW_WR, ST_DONE} st_e;

  st_e                 st;
  logic                r_write, r_err;
  logic [1:0]          r_nat, r_acc_code;
  logic [SPACE_AW-1:0] r_addr;
  logic [2:0]          r_left;
  logic [DATA_W-1:0]   r_wdata, r_acc;

  // Named events for the checker.
  logic       accept, acc_err, misalign;
  logic [1:0] req_nat;
  logic [2:0] req_bytes, req_nat_bytes, nat_bytes, acc_bytes;

  regw_width_rom #(.MAP(WIDTH_MAP)) i_rom (
    .grp  (req_addr[SPACE_AW-1:2]),
    .code (req_nat)
  );

  assign accept        = req_valid && (st == ST_IDLE);
  assign req_bytes     = sz_bytes(req_size);
  assign req_nat_bytes = sz_bytes(req_nat);
  assign misalign      = ((req_size == SZ_HALF) && req_addr[0]) ||
                         ((req_size == SZ_WORD) && (req_addr[1:0] != 2'b00));
  assign acc_err       = req_addr[ADDR_W-1] || (req_size == SZ_NONE) || misalign ||
                         (req_nat == SZ_NONE);

  assign nat_bytes = sz_bytes(r_nat);
  assign acc_bytes = sz_bytes(r_acc_code);

  logic [SPACE_AW-1:0] cont_addr;
  logic [1:0]          offs;
  logic [DATA_W-1:0]   lane_in, lane_ext, lane_mrg, nat_mask;
  logic [5:0]          psh;

  assign offs      = r_addr[1:0] & 2'(nat_bytes - 3'd1);
  assign cont_addr = {r_addr[SPACE_AW-1:2], r_addr[1:0] & ~2'(nat_bytes - 3'd1)};
  assign lane_in   = (st == ST_RMW_RD) ? dn_rdata : r_acc;
  assign nat_mask  = byte_mask(nat_bytes);
  assign psh       = piece_shift(r_left, nat_bytes);

  regw_lane_unit i_lane (
    .container (lane_in),
    .wdata     (r_wdata),
    .nat_bytes (nat_bytes),
    .acc_bytes (acc_bytes),
    .offs      (offs),
    .extract   (lane_ext),
    .merged    (lane_mrg)
  );

  always_comb begin
    dn_valid = 1'b0;
    dn_write = 1'b0;
    dn_size  = r_nat;
    dn_addr  = cont_addr;
    dn_wdata = '0;
    unique case (st)
      ST_SPLIT: begin
        dn_valid = 1'b1;
        dn_write = r_write;
        dn_addr  = r_addr;
        dn_wdata = r_write ? ((r_wdata >> psh) & nat_mask) : '0;
      end
      ST_RMW_RD: dn_valid = 1'b1;
      ST_RMW_WR: begin
        dn_valid = 1'b1;
        dn_write = 1'b1;
        dn_wdata = lane_mrg;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      r_write    <= 1'b0;
      r_err      <= 1'b0;
      r_nat      <= SZ_NONE;
      r_acc_code <= SZ_NONE;
      r_addr     <= '0;
      r_left     <= '0;
      r_wdata    <= '0;
      r_acc      <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          r_write    <= req_write;
          r_nat      <= req_nat;
          r_acc_code <= req_size;
          r_addr     <= req_addr[SPACE_AW-1:0];
          r_wdata    <= req_wdata & byte_mask(req_bytes);
          r_acc      <= '0;
          r_err      <= acc_err;
          r_left     <= op_count(req_bytes, req_nat_bytes);
          if (acc_err)                         st <= ST_DONE;
          else if (req_bytes >= req_nat_bytes) st <= ST_SPLIT;
          else                                 st <= ST_RMW_RD;
        end
        ST_SPLIT: begin
          if (!r_write) r_acc <= (r_acc << {nat_bytes, 3'b000}) | (dn_rdata & nat_mask);
          r_addr <= r_addr + SPACE_AW'(nat_bytes);
          r_left <= r_left - 3'd1;
          if (r_left == 3'd1) st <= ST_DONE;
        end
        ST_RMW_RD: begin
          if (r_write) begin
            r_acc <= dn_rdata & nat_mask;
            st    <= ST_RMW_WR;
          end else begin
            r_acc <= lane_ext;
            st    <= ST_DONE;
          end
        end
        ST_RMW_WR: st <= ST_DONE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (st != ST_IDLE);
  assign done  = (st == ST_DONE);
  assign err   = done && r_err;
  assign rdata = (done && !r_write && !r_err) ? r_acc : '0;
endmodule

// File: rtl/regw_adapter_chk.sv
module regw_adapter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       acc_err,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       dn_valid,
  input logic [1:0] dn_size,
  input logic [8:0] dn_addr
);
  // R2
  err_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && acc_err |=> done && err);
  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && acc_err |=> !dn_valid);
  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !acc_err |=> dn_valid && !done);
  // R7
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_size != 2'd0) && (dn_size != 2'd2 || !dn_addr[0]) &&
                 (dn_size != 2'd3 || dn_addr[1:0] == 2'b00));
  // R9
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid || done) |-> busy);
  // R9
  done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !dn_valid);
endmodule

bind regw_adapter regw_adapter_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .acc_err  (acc_err),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .dn_valid (dn_valid),
  .dn_size  (dn_size),
  .dn_addr  (dn_addr)
);

// File: tb/test_regw_adapter.sv
module test_regw_adapter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, err, dn_valid, dn_write;
  logic [31:0] rdata, dn_wdata, dn_rdata;
  logic [1:0]  dn_size;
  logic [8:0]  dn_addr;

  int total = 0, fails = 0;

  always #5 clk = ~clk;

  regw_adapter i_regw_adapter (.*);

  // Register space model and the expected shadow copy.
  logic [7:0] mem [512];
  logic [7:0] shadow [512];

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'd3) ? 4 : int'(c);
  endfunction
  // R8: group width from address bits 7:6
  function automatic logic [1:0] natcode(input logic [8:0] a);
    return a[7:6] + 2'd1;
  endfunction

  always_comb begin
    dn_rdata = '0;
    for (int i = 0; i < nbytes(dn_size); i++)
      dn_rdata = (dn_rdata << 8) | 32'(mem[9'(int'(dn_addr) + i)]);
  end

  always @(posedge clk)
    if (dn_valid && dn_write)
      for (int i = 0; i < nbytes(dn_size); i++)
        mem[9'(int'(dn_addr) + i)] <= dn_wdata[8*(nbytes(dn_size)-1-i) +: 8];

  typedef struct {
    logic [31:0] rd;
    logic        er;
    int          ops;
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [1:0] sz, input logic [9:0] a,
                        input logic [31:0] wd, input string tag);
    exp_t e;
    int s, n;
    bit bad;
    s = nbytes(sz);
    n = nbytes(natcode(a[8:0]));
    bad = a[9] || sz == 2'd0 || (sz == 2'd2 && a[0]) || (sz == 2'd3 && a[1:0] != 0) || n == 0;
    e.tag = tag; e.er = bad; e.rd = '0; e.ops = 0;
    if (!bad) begin
      e.ops = (s >= n) ? s / n : (w ? 2 : 1);
      for (int i = 0; i < s; i++) begin
        if (w) shadow[int'(a[8:0]) + i] = wd[8*(s-1-i) +: 8];
        else   e.rd = (e.rd << 8) | 32'(shadow[int'(a[8:0]) + i]);
      end
    end
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  int cyc = 0, ops = 0;
  always @(negedge clk) if (rst_n) begin
    if (busy) cyc++;
    if (dn_valid) begin
      ops++;
      // R7: native size and alignment of every downstream op
      check(dn_size == natcode(dn_addr) && (int'(dn_addr) % nbytes(dn_size)) == 0,
            "R7 dn op size/align", 32'({dn_size, dn_addr}), 32'({natcode(dn_addr), dn_addr}));
    end
    if (done) begin
      if (sb.size() == 0) check(0, "R9 done without request", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(err == e.er, {e.tag, " err"}, 32'(err), 32'(e.er));
        check(rdata == e.rd, {e.tag, " rdata"}, rdata, e.rd);
        check(ops == e.ops, {e.tag, " op count"}, 32'(ops), 32'(e.ops));
        check(cyc == e.ops + 1, {e.tag, " R9 latency"}, 32'(cyc), 32'(e.ops + 1));
      end
      cyc = 0; ops = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !dn_valid, "R1 in reset", 32'({busy, done, dn_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !dn_valid, "R1 after reset", 32'({busy, done, dn_valid}), 0);

    // R3 matched width, R8 region types
    access(0, 2'd1, 10'h005, 0, "R3 byte rd byte reg");
    access(1, 2'd1, 10'h006, 32'h5a, "R3 byte wr byte reg");
    access(0, 2'd2, 10'h042, 0, "R3 half rd half reg");
    access(1, 2'd3, 10'h084, 32'hdeadbeef, "R3 word wr word reg");
    access(0, 2'd3, 10'h184, 0, "R8 word rd upper word region");
    // R4 narrow reads
    access(0, 2'd1, 10'h044, 0, "R4 byte rd even of half");
    access(0, 2'd1, 10'h045, 0, "R4 byte rd odd of half");
    for (int k = 0; k < 4; k++) access(0, 2'd1, 10'(10'h084 + k), 0, "R4 byte rd of word");
    access(0, 2'd2, 10'h088, 0, "R4 half rd upper of word");
    access(0, 2'd2, 10'h08a, 0, "R4 half rd lower of word");
    // R5 narrow writes and readback
    access(1, 2'd1, 10'h049, 32'h11, "R5 byte wr odd of half");
    access(0, 2'd2, 10'h048, 0, "R5 readback half");
    access(1, 2'd1, 10'h092, 32'h22, "R5 byte wr lane2 of word");
    access(1, 2'd2, 10'h094, 32'h3344, "R5 half wr upper of word");
    access(0, 2'd3, 10'h090, 0, "R5 readback word");
    access(0, 2'd3, 10'h094, 0, "R5 readback word2");
    // R6 wide accesses
    access(0, 2'd2, 10'h010, 0, "R6 half rd byte regs");
    access(1, 2'd3, 10'h020, 32'ha1b2c3d4, "R6 word wr byte regs");
    access(0, 2'd3, 10'h020, 0, "R6 word rd byte regs");
    access(1, 2'd3, 10'h050, 32'h01020304, "R6 word wr half regs");
    access(0, 2'd3, 10'h050, 0, "R6 word rd half regs");
    // R10 mixed-width consistency
    access(0, 2'd1, 10'h052, 0, "R10 byte rd after word wr");
    access(0, 2'd2, 10'h022, 0, "R10 half rd after word wr");
    // R2 errors
    access(0, 2'd1, 10'h200, 0, "R2 out of range");
    access(1, 2'd0, 10'h004, 32'hff, "R2 size zero");
    access(0, 2'd2, 10'h041, 0, "R2 misaligned half");
    access(1, 2'd3, 10'h042, 32'h1, "R2 misaligned word");
    access(1, 2'd1, 10'h0c0, 32'h77, "R2 unused group");
    access(0, 2'd3, 10'h1c4, 0, "R2 unused upper group");

    repeat (2) @(negedge clk);
    begin
      int bad = 0;
      for (int i = 0; i < 512; i++) if (mem[i] !== shadow[i]) bad++;
      check(bad == 0, "R5 R10 final space image", 32'(bad), 0);
    end
    check(sb.size() == 0, "R9 all requests completed", 32'(sb.size()), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule